// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block sits between a load/store unit and a word-addressed backing memory. It keeps a copy of recently loaded 64-bit words so that later loads to the same line are served without a memory transaction. Capacity is 64 bytes, organised as four lines of 16 bytes. Each line holds two 64-bit words, and each line has one tag and one valid bit. Every address maps to exactly one line.

The CPU side presents one request at a time with `req_valid` while `req_ready` is high. A request carries a byte address that is a multiple of 8, a write flag and, for stores, the data. Each request finishes with a single-cycle `rsp_valid` pulse. That pulse carries a hit flag and, for loads, the data. On the memory side, the block raises `mem_req` and holds the address, direction and data until the memory answers with `mem_ack`. For reads, `mem_rdata` is sampled in the acknowledge cycle.

Loads that miss fetch the whole line and then answer. Stores never wait for a line and never bring one in. Every store is written to memory, and a store that hits also refreshes the cached copy of the word.

Top module: `dc_wt_cache`

## Requirements
- R1: After reset every line is invalid, so the first load to any address reports a miss. While idle, `req_ready` is 1 and both `rsp_valid` and `mem_req` are 0.
- R2: A load miss issues exactly two memory reads, word 0 of the line first and then word 1, at word addresses `{addr[15:4],1'b0}` and `{addr[15:4],1'b1}`. It then responds with hit=0 and the requested word.
- R3: A load to a valid line with a matching tag responds with hit=1 and the cached word, and issues no memory transaction.
- R4: Byte address bit [3] selects the word in a line, bits [5:4] select the line and bits [15:6] form the tag. Bits [2:0] are always zero. A load whose tag differs from the stored one for its line misses and replaces that line.
- R5: Every store, hit or miss, performs exactly one memory write of the store data to word address `addr[15:3]`, and issues no memory read.
- R6: A store that hits responds with hit=1 and updates the cached word, so a later load to that address hits and returns the stored data.
- R7: A store that misses responds with hit=0 and leaves tags, valid bits and cached data unchanged. A later load to that address misses and returns the stored data, and a line already cached at the same index still hits with its old data.
- R8: `rsp_valid` is high for exactly one cycle per accepted request, and `req_ready` is low from acceptance until that response.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` keep their values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Byte address, multiple of 8 |
| req_wdata | input | 64 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Hit status of the completed request |
| rsp_rdata | output | 64 | Load data, valid with `rsp_valid` on loads |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 13 | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Memory completes the current beat |
| mem_rdata | input | 64 | Memory read data, valid with `mem_ack` |

## Verification
The bench targets four corner cases.

- **Store miss followed by a load to the same line.** A design that allocated on a store would report a hit instead of a miss on that load.
- **Store miss to an index already holding another tag.** A design that allocated would evict the old line, so the following load of that line would miss.
- **Two loads with equal index and different tags.** If the tag compare were wrong or missing, the second load would return stale data as a hit.
- **Response and memory timing.** The memory model waits several cycles before acknowledging, and the bench checks the order and addresses of the fill beats and the address and data of every write. This exposes a fill that swaps words, a store hit that skips memory, and a request that drifts before its acknowledge.

// File: rtl/dcwt_pkg.sv
package dcwt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_FILL,
      ST_RESP,
      ST_STORE
   } dc_state_e;
endpackage

// File: rtl/dcwt_tag_store.sv
module dcwt_tag_store #(
   parameter int LINES = 4,
   parameter int IDX_W = 2,
   parameter int TAG_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   for (genvar l = 0; l < LINES; l++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[l] <= 1'b0;
            tag_q[l]   <= '0;
         end else if (wr_en && wr_idx == IDX_W'(l)) begin
            valid_q[l] <= 1'b1;
            tag_q[l]   <= wr_tag;
         end
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

   // R1: first cycle out of reset sees every line invalid
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> valid_q == '0);
endmodule

// File: rtl/dcwt_data_store.sv
module dcwt_data_store #(
   parameter int LINES  = 4,
   parameter int WORDS  = 2,
   parameter int DATA_W = 64,
   parameter int IDX_W  = 2,
   parameter int WSEL_W = 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_wsel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WSEL_W-1:0] rd_wsel,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] word_q [LINES][WORDS];

   for (genvar l = 0; l < LINES; l++) begin : g_line
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(l) && wr_wsel == WSEL_W'(w))
               word_q[l][w] <= wr_data;
         end
      end
   end

   assign rd_data = word_q[rd_idx][rd_wsel];
endmodule

// File: rtl/dcwt_ctrl.sv
module dcwt_ctrl
   import dcwt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 64,
   parameter int OFF_W  = 3,
   parameter int WSEL_W = 1,
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 10,
   parameter int WORDS  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic [ADDR_W-OFF_W-1:0] req_waddr,
   input  logic [DATA_W-1:0]       req_wdata,
   output logic                    rsp_valid,
   output logic                    rsp_hit,
   input  logic                    lk_valid,
   input  logic [TAG_W-1:0]        lk_tag,
   output logic [IDX_W-1:0]        cur_idx,
   output logic [TAG_W-1:0]        cur_tag,
   output logic [WSEL_W-1:0]       cur_wsel,
   output logic                    tag_we,
   output logic                    dat_we,
   output logic [WSEL_W-1:0]       dat_wsel,
   output logic [DATA_W-1:0]       dat_wdata,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-OFF_W-1:0] mem_addr,
   output logic [DATA_W-1:0]       mem_wdata,
   input  logic                    mem_ack,
   input  logic [DATA_W-1:0]       mem_rdata
);
   localparam int MADDR_W = ADDR_W - OFF_W;
   localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

   dc_state_e           state_q;
   logic [MADDR_W-1:0]  wa_q;
   logic [DATA_W-1:0]   wd_q;
   logic                wr_q;
   logic                hit_q;
   logic [WSEL_W-1:0]   beat_q;
   logic                hit;

   assign cur_wsel = wa_q[WSEL_W-1:0];
   assign cur_idx  = wa_q[WSEL_W +: IDX_W];
   assign cur_tag  = wa_q[MADDR_W-1 -: TAG_W];
   assign hit      = lk_valid && (lk_tag == cur_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wa_q    <= '0;
         wd_q    <= '0;
         wr_q    <= 1'b0;
         hit_q   <= 1'b0;
         beat_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               wa_q    <= req_waddr;
               wd_q    <= req_wdata;
               wr_q    <= req_write;
               state_q <= ST_LOOK;
            end
            ST_LOOK: begin
               hit_q <= hit;
               if (wr_q)     state_q <= ST_STORE;
               else if (hit) state_q <= ST_IDLE;
               else begin
                  beat_q  <= '0;
                  state_q <= ST_FILL;
               end
            end
            ST_FILL: if (mem_ack) begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == LAST_BEAT) state_q <= ST_RESP;
            end
            ST_RESP:  state_q <= ST_IDLE;
            ST_STORE: if (mem_ack) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready = (state_q == ST_IDLE);
      rsp_valid = 1'b0;
      rsp_hit   = 1'b0;
      case (state_q)
         ST_LOOK:  if (!wr_q && hit) begin rsp_valid = 1'b1; rsp_hit = 1'b1; end
         ST_RESP:  rsp_valid = 1'b1;
         ST_STORE: if (mem_ack) begin rsp_valid = 1'b1; rsp_hit = hit_q; end
         default: ;
      endcase
   end

   always_comb begin
      dat_we    = 1'b0;
      dat_wsel  = cur_wsel;
      dat_wdata = wd_q;
      tag_we    = 1'b0;
      if (state_q == ST_LOOK && wr_q && hit) dat_we = 1'b1;
      if (state_q == ST_FILL && mem_ack) begin
         dat_we    = 1'b1;
         dat_wsel  = beat_q;
         dat_wdata = mem_rdata;
         tag_we    = (beat_q == LAST_BEAT);
      end
   end

   assign mem_req   = (state_q == ST_FILL) || (state_q == ST_STORE);
   assign mem_we    = (state_q == ST_STORE);
   assign mem_addr  = mem_we ? wa_q : {wa_q[MADDR_W-1:WSEL_W], beat_q};
   assign mem_wdata = wd_q;

   assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
   assert_store_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && wr_q) |-> (mem_req && mem_we && mem_ack));
   assert_hit_nomem_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && !wr_q) |-> !mem_req);
   assert_no_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tag_we |-> !wr_q);
   assert_fill_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !wr_q && !rsp_hit) |-> $past(tag_we));
endmodule

// File: rtl/dc_wt_cache.sv
module dc_wt_cache #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 64,
   parameter int CACHE_BYTES = 64,
   parameter int LINE_BYTES  = 16,
   localparam int WORD_BYTES = DATA_W / 8,
   localparam int OFF_W      = $clog2(WORD_BYTES),
   localparam int MADDR_W    = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               rsp_valid,
   output logic               rsp_hit,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [MADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic               mem_ack,
   input  logic [DATA_W-1:0]  mem_rdata
);
   localparam int WORDS  = LINE_BYTES / WORD_BYTES;
   localparam int WSEL_W = $clog2(WORDS);
   localparam int LINES  = CACHE_BYTES / LINE_BYTES;
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = MADDR_W - WSEL_W - IDX_W;

   if (DATA_W % 8 != 0 || (1 << OFF_W) != WORD_BYTES) begin : g_bad_word
      $error("DATA_W must give a power-of-two byte count");
   end
   if (WORDS < 2 || (1 << WSEL_W) != WORDS || LINE_BYTES % WORD_BYTES != 0) begin : g_bad_line
      $error("line must hold a power-of-two number of words, at least two");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("line count must be a power of two, at least two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the cache geometry");
   end

   logic               lk_valid;
   logic [TAG_W-1:0]   lk_tag;
   logic [IDX_W-1:0]   cur_idx;
   logic [TAG_W-1:0]   cur_tag;
   logic [WSEL_W-1:0]  cur_wsel;
   logic               tag_we;
   logic               dat_we;
   logic [WSEL_W-1:0]  dat_wsel;
   logic [DATA_W-1:0]  dat_wdata;

   dcwt_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .WSEL_W(WSEL_W),
      .IDX_W(IDX_W), .TAG_W(TAG_W), .WORDS(WORDS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_waddr(req_addr[ADDR_W-1:OFF_W]), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .lk_valid(lk_valid), .lk_tag(lk_tag),
      .cur_idx(cur_idx), .cur_tag(cur_tag), .cur_wsel(cur_wsel),
      .tag_we(tag_we), .dat_we(dat_we), .dat_wsel(dat_wsel), .dat_wdata(dat_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   dcwt_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(cur_idx), .rd_valid(lk_valid), .rd_tag(lk_tag),
      .wr_en(tag_we), .wr_idx(cur_idx), .wr_tag(cur_tag)
   );

   dcwt_data_store #(
      .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
   ) u_data (
      .clk(clk),
      .wr_en(dat_we), .wr_idx(cur_idx), .wr_wsel(dat_wsel), .wr_data(dat_wdata),
      .rd_idx(cur_idx), .rd_wsel(cur_wsel), .rd_data(rsp_rdata)
   );

   // R4: requests carry word-aligned byte addresses
   assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> req_addr[OFF_W-1:0] == '0);
endmodule

// File: tb/sim_dc_wt_cache.sv
module sim_dc_wt_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic        rsp_hit;
   logic [63:0] rsp_rdata;
   logic        mem_req;
   logic        mem_we;
   logic [12:0] mem_addr;
   logic [63:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;

   always #10 clk = ~clk;

   dc_wt_cache u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   typedef struct {
      bit          wr;
      bit          hit;
      logic [63:0] data;
      int          nrd;
      int          nwr;
      logic [12:0] rbase;
      logic [12:0] waddr;
      logic [63:0] wdata;
      string       note;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0, errors = 0;
   int   mchecks = 0, merrors = 0;

   // behavioural backing memory with a three-cycle acknowledge
   logic [63:0] mem [64];
   logic [1:0]  wcnt = '0;
   logic [12:0] a0 = '0;
   int          tot_rd = 0, tot_wr = 0;
   logic [12:0] rd_prev = '0, rd_last = '0, wa_last = '0;
   logic [63:0] wd_last = '0;

   initial for (int i = 0; i < 64; i++) mem[i] = 64'hA5A5_0000_0000_0000 + 64'(i * 17);

   always @(posedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
         wcnt    <= '0;
      end else if (mem_req) begin
         if (wcnt == 0) a0 <= mem_addr;
         if (wcnt == 2) begin
            mem_ack <= 1'b1;
            mchecks <= mchecks + 1;
            if (mem_addr != a0) begin
               merrors <= merrors + 1;
               $display("FAIL R9 address moved before ack: actual %h expected %h", mem_addr, a0);
            end
            if (mem_we) begin
               mem[mem_addr[5:0]] <= mem_wdata;
               tot_wr  <= tot_wr + 1;
               wa_last <= mem_addr;
               wd_last <= mem_wdata;
            end else begin
               mem_rdata <= mem[mem_addr[5:0]];
               tot_rd    <= tot_rd + 1;
               rd_prev   <= rd_last;
               rd_last   <= mem_addr;
            end
         end else begin
            wcnt <= wcnt + 1'b1;
         end
      end
   end

   task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, expv);
      end
   endtask

   // monitor: compare each response against the scoreboard
   int base_rd = 0, base_wr = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               chk(0, "R8 response with no request", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(rsp_hit == e.hit, {e.note, " hit flag"}, 64'(rsp_hit), 64'(e.hit));
               if (!e.wr)
                  chk(rsp_rdata == e.data, {e.note, " load data"}, rsp_rdata, e.data);
               chk(tot_rd - base_rd == e.nrd, {e.note, " memory read count"},
                   64'(tot_rd - base_rd), 64'(e.nrd));
               chk(tot_wr - base_wr == e.nwr, {e.note, " memory write count"},
                   64'(tot_wr - base_wr), 64'(e.nwr));
               if (e.nrd == 2) begin
                  chk(rd_prev == e.rbase, {e.note, " R2 first fill beat"}, 64'(rd_prev), 64'(e.rbase));
                  chk(rd_last == (e.rbase | 13'd1), {e.note, " R2 second fill beat"},
                      64'(rd_last), 64'(e.rbase | 13'd1));
               end
               if (e.wr) begin
                  chk(wa_last == e.waddr, {e.note, " R5 write address"}, 64'(wa_last), 64'(e.waddr));
                  chk(wd_last == e.wdata, {e.note, " R5 write data"}, wd_last, e.wdata);
               end
            end
            base_rd = tot_rd;
            base_wr = tot_wr;
            @(negedge clk);
            chk(!rsp_valid, "R8 response lasts one cycle", 64'(rsp_valid), 64'd0);
         end
      end
   end

   // reference model built from the requirements
   logic [63:0] shadow [64];
   bit          m_valid [4];
   logic [9:0]  m_tag [4];
   initial for (int i = 0; i < 64; i++) shadow[i] = 64'hA5A5_0000_0000_0000 + 64'(i * 17);

   task automatic access(bit wr, logic [15:0] a, logic [63:0] d, string note);
      exp_t e;
      int   ix;
      bit   h;
      ix = int'(a[5:4]);
      h  = m_valid[ix] && (m_tag[ix] == a[15:6]);
      e.wr = wr; e.hit = h; e.note = note;
      e.rbase = {a[15:4], 1'b0};
      e.waddr = a[15:3];
      e.wdata = d;
      if (wr) begin
         shadow[a[8:3]] = d;
         e.nrd = 0; e.nwr = 1; e.data = '0;
      end else begin
         e.nrd = h ? 0 : 2; e.nwr = 0;
         e.data = shadow[a[8:3]];
         m_valid[ix] = 1'b1;
         m_tag[ix]   = a[15:6];
      end
      exp_q.push_back(e);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      chk(!req_ready, {note, " R8 busy after accept"}, 64'(req_ready), 64'd0);
      req_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 idle ready after reset", 64'(req_ready), 64'd1);
      chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
      chk(mem_req == 1'b0, "R1 no memory request after reset", 64'(mem_req), 64'd0);

      access(0, 16'h0010, '0, "R1 R2 cold load miss");
      access(0, 16'h0018, '0, "R3 hit other word");
      access(0, 16'h0010, '0, "R3 hit first word");
      access(0, 16'h0028, '0, "R2 miss on word one");
      access(0, 16'h0020, '0, "R3 hit word zero");
      access(1, 16'h0018, 64'h1111_2222_3333_4444, "R5 R6 store hit");
      access(0, 16'h0018, '0, "R6 load after store hit");
      access(1, 16'h0030, 64'h5555_6666_7777_8888, "R5 R7 store miss");
      access(0, 16'h0038, '0, "R7 no allocate on store miss");
      access(0, 16'h0030, '0, "R7 stored data via memory");
      access(0, 16'h0050, '0, "R4 conflict evicts line one");
      access(0, 16'h0010, '0, "R4 evicted line misses");
      access(1, 16'h0060, 64'h9999_AAAA_BBBB_CCCC, "R7 store miss other tag");
      access(0, 16'h0028, '0, "R7 resident line kept");
      access(0, 16'h0060, '0, "R7 R4 conflict load");
      for (int k = 0; k < 8; k++) begin
         logic [15:0] ad;
         ad = 16'(16'h0080 + k * 8);
         access(0, ad, '0, "R2 R3 loop load");
         access(1, ad, 64'(k) << 8 | 64'hF0, "R5 R6 loop store");
         access(0, ad, '0, "R6 loop reload");
      end
      access(0, 16'h00C0, '0, "R4 wrap tag load");
      access(0, 16'h0080, '0, "R4 reload after eviction");

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors + merrors, checks + mchecks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors + merrors + 1, checks + mchecks + 1);
      $finish;
   end
endmodule